// File: doc/BRIEF.md
# Bayer Line Demultiplexer with Optical-Black Clamp

This block sits directly behind the analog front end of a colour-mosaic CCD readout chain. It takes the digitized serial sample stream and uses line and frame markers to keep track of where each sample falls in the sensor geometry. Every sample is either a dummy bit, an optical-black sample or an effective pixel. Effective pixels are tagged with their mosaic channel. Lines alternate between a red/green line and a green/blue line, and along a line green alternates with the line's other colour.

The trailing optical-black columns of each line are summed, and when the next line starts the sum is turned into an average by a fixed-point reciprocal multiply. That average is the black reference for the new line. Each effective pixel is output with the reference subtracted and the result clamped at zero, and each output sample carries a channel tag and a valid strobe. Two configuration inputs set the colour phase of the first effective line and the first effective column. Every geometry count is a parameter.

Top module: `bayer_clamp_demux`

## Requirements
- R1: While reset is held and at its release, `outValid`, `outData` and `outChan` are zero, and the black reference is zero until a line boundary loads a new one.
- R2: After a `lineStart`, samples are indexed from 0 by `pixValid` cycles. Only indices from DUMMY_COLS+LEAD_OB_COLS through DUMMY_COLS+LEAD_OB_COLS+EFF_COLS-1 can produce an output. Indices past the last optical-black column, and every sample between a `frameStart` and the first `lineStart`, produce nothing.
- R3: After a `frameStart`, lines are indexed from 0 by `lineStart` pulses. Only lines LEAD_OB_LINES through LEAD_OB_LINES+EFF_LINES-1 produce output.
- R4: An output sample appears with `outValid` high in the cycle right after the clock edge that captured its input sample.
- R5: `outChan` uses 0 = green on a red line, 1 = red, 2 = green on a blue line and 3 = blue. The first effective line is a red line when `cfgFirstRed` is 1 and a blue line when it is 0, and the line type alternates from one line to the next.
- R6: The first effective column is green when `cfgFirstGreen` is 1. Along a line the tag alternates between green and the line's other colour.
- R7: At each `lineStart` the black reference becomes (S * round(65536/TRAIL_OB_COLS)) >> 16, saturated to the data range. S is the sum of the samples at indices TOTAL_COLS-TRAIL_OB_COLS through TOTAL_COLS-1 of the line just ended, including optical-black lines. With a power-of-two count this equals floor(S/TRAIL_OB_COLS).
- R8: `outData` equals the input sample minus the black reference when the sample is larger than the reference, and 0 otherwise.
- R9: In a cycle with `lineStart` or `frameStart` high, `pixValid` is ignored: the sample is not counted, not summed and not output. `frameStart` takes priority over `lineStart`.
- R10: Cycles with `pixValid` low do not advance the column index and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Input sample strobe |
| pixData | input | DATA_W | Digitized sample |
| lineStart | input | 1 | One-cycle pulse before a line's first sample |
| frameStart | input | 1 | One-cycle pulse before a frame's first line |
| cfgFirstRed | input | 1 | 1: first effective line is a red/green line |
| cfgFirstGreen | input | 1 | 1: first effective column is green |
| outValid | output | 1 | Corrected effective pixel strobe |
| outData | output | DATA_W | Black-corrected, zero-clamped sample |
| outChan | output | 2 | Channel tag (0 Gr, 1 R, 2 Gb, 3 B) |

## Verification
The bench drives whole frames that cover all four combinations of the two phase inputs. This separates a swapped line phase from a swapped column phase. Optical-black levels vary by a few codes across columns and lines, so the reference differs from line to line: a reference taken from the wrong line or from the wrong columns shows up as a data mismatch. One frame places effective pixels below the reference to exercise the clamp. Other frames put idle cycles between samples and raise `lineStart` together with a strong sample, which shows whether gaps and marker cycles are counted.

// File: rtl/bayer_pkg.sv
package bayer_pkg;

  typedef enum logic [1:0] {
    CH_GR = 2'd0,
    CH_R  = 2'd1,
    CH_GB = 2'd2,
    CH_B  = 2'd3
  } chan_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  accumulate;  // sample lies in trailing optical-black columns
    logic  emit;        // sample is an effective pixel in an effective line
    logic  newLine;     // line boundary: latch reference, clear sum
    chan_e chan;        // mosaic channel of this sample
  } ctl_t;

endpackage

// File: rtl/bayer_ctrl.sv
module bayer_ctrl
  import bayer_pkg::*;
#(
  parameter int DUMMY_COLS     = 16,
  parameter int LEAD_OB_COLS   = 2,
  parameter int EFF_COLS       = 659,
  parameter int TRAIL_OB_COLS  = 31,
  parameter int LEAD_OB_LINES  = 8,
  parameter int EFF_LINES      = 494,
  parameter int TRAIL_OB_LINES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pixValid,
  input  logic lineStart,
  input  logic frameStart,
  input  logic cfgFirstRed,
  input  logic cfgFirstGreen,
  output ctl_t ctl
);

  localparam int TOTAL_COLS  = DUMMY_COLS + LEAD_OB_COLS + EFF_COLS + TRAIL_OB_COLS;
  localparam int TOTAL_LINES = LEAD_OB_LINES + EFF_LINES + TRAIL_OB_LINES;
  localparam int COL_W = $clog2(TOTAL_COLS + 1);
  localparam int ROW_W = $clog2(TOTAL_LINES + 2);
  localparam int EFF_LO = DUMMY_COLS + LEAD_OB_COLS;

  localparam logic [COL_W-1:0] C_TOTAL  = COL_W'(TOTAL_COLS);
  localparam logic [COL_W-1:0] C_EFF_LO = COL_W'(EFF_LO);
  localparam logic [COL_W-1:0] C_EFF_HI = COL_W'(EFF_LO + EFF_COLS);
  localparam logic [COL_W-1:0] C_TRL_LO = COL_W'(TOTAL_COLS - TRAIL_OB_COLS);
  localparam logic [ROW_W-1:0] R_TOTAL  = ROW_W'(TOTAL_LINES);
  localparam logic [ROW_W-1:0] R_EFF_LO = ROW_W'(LEAD_OB_LINES);
  localparam logic [ROW_W-1:0] R_EFF_HI = ROW_W'(LEAD_OB_LINES + EFF_LINES);
  localparam logic COL_PAR = EFF_LO[0];
  localparam logic ROW_PAR = LEAD_OB_LINES[0];

  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] lineCnt;
  logic sampleOk, colEff, rowEff, redLine, greenCol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colCnt  <= C_TOTAL;
      lineCnt <= '1;
    end else if (frameStart) begin
      colCnt  <= C_TOTAL;
      lineCnt <= '1;
    end else if (lineStart) begin
      colCnt <= '0;
      if (lineCnt != R_TOTAL) lineCnt <= lineCnt + 1'b1;
    end else if (pixValid && colCnt != C_TOTAL) begin
      colCnt <= colCnt + 1'b1;
    end
  end

  always_comb begin
    sampleOk = pixValid && !lineStart && !frameStart;
    colEff   = (colCnt >= C_EFF_LO) && (colCnt < C_EFF_HI);
    rowEff   = (lineCnt >= R_EFF_LO) && (lineCnt < R_EFF_HI);
    redLine  = cfgFirstRed ^ lineCnt[0] ^ ROW_PAR;
    greenCol = cfgFirstGreen ^ colCnt[0] ^ COL_PAR;
    ctl.accumulate = sampleOk && (colCnt >= C_TRL_LO) && (colCnt < C_TOTAL);
    ctl.emit       = sampleOk && colEff && rowEff;
    ctl.newLine    = lineStart && !frameStart;
    ctl.chan       = chan_e'({~redLine, ~greenCol});
  end

endmodule

// File: rtl/bayer_dp.sv
module bayer_dp
  import bayer_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int TRAIL_OB_COLS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] pixData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outChan
);

  localparam int ACC_W = DATA_W + $clog2(TRAIL_OB_COLS + 1);
  localparam int SHIFT = 16;
  localparam int PROD_W = ACC_W + SHIFT + 1;
  localparam int RECIP = ((1 << SHIFT) + TRAIL_OB_COLS / 2) / TRAIL_OB_COLS;
  localparam logic [PROD_W-1:0] RECIP_W = PROD_W'(RECIP);
  localparam logic [ACC_W-1:0]  MAX_A   = ACC_W'((1 << DATA_W) - 1);

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  avgRaw;
  logic [DATA_W-1:0] avgSat;
  logic [DATA_W-1:0] blackRef;
  logic [DATA_W-1:0] diff;

  generate
    if ((TRAIL_OB_COLS & (TRAIL_OB_COLS - 1)) == 0) begin : g_shift
      assign avgRaw = acc >> $clog2(TRAIL_OB_COLS);
    end else begin : g_mul
      logic [PROD_W-1:0] prod;
      assign prod   = {{(SHIFT + 1){1'b0}}, acc} * RECIP_W;
      assign avgRaw = prod[ACC_W+SHIFT-1:SHIFT];
    end
  endgenerate

  always_comb begin
    avgSat = (avgRaw > MAX_A) ? '1 : avgRaw[DATA_W-1:0];
    diff   = (pixData > blackRef) ? (pixData - blackRef) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      blackRef <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outChan  <= '0;
    end else begin
      if (ctl.newLine) begin
        blackRef <= avgSat;
        acc      <= '0;
      end else if (ctl.accumulate) begin
        acc <= acc + ACC_W'(pixData);
      end
      outValid <= ctl.emit;
      if (ctl.emit) begin
        outData <= diff;
        outChan <= ctl.chan;
      end
    end
  end

endmodule

// File: rtl/bayer_clamp_demux.sv
module bayer_clamp_demux
  import bayer_pkg::*;
#(
  parameter int DATA_W         = 12,
  parameter int DUMMY_COLS     = 16,
  parameter int LEAD_OB_COLS   = 2,
  parameter int EFF_COLS       = 659,
  parameter int TRAIL_OB_COLS  = 31,
  parameter int LEAD_OB_LINES  = 8,
  parameter int EFF_LINES      = 494,
  parameter int TRAIL_OB_LINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic              cfgFirstRed,
  input  logic              cfgFirstGreen,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outChan
);

  ctl_t ctl;

  bayer_ctrl #(
    .DUMMY_COLS(DUMMY_COLS), .LEAD_OB_COLS(LEAD_OB_COLS), .EFF_COLS(EFF_COLS),
    .TRAIL_OB_COLS(TRAIL_OB_COLS), .LEAD_OB_LINES(LEAD_OB_LINES),
    .EFF_LINES(EFF_LINES), .TRAIL_OB_LINES(TRAIL_OB_LINES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .lineStart(lineStart),
    .frameStart(frameStart), .cfgFirstRed(cfgFirstRed),
    .cfgFirstGreen(cfgFirstGreen), .ctl(ctl)
  );

  bayer_dp #(.DATA_W(DATA_W), .TRAIL_OB_COLS(TRAIL_OB_COLS)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pixData(pixData),
    .outValid(outValid), .outData(outData), .outChan(outChan)
  );

endmodule

// File: rtl/bayer_clamp_demux_chk.sv
module bayer_clamp_demux_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pixValid,
  input logic [DATA_W-1:0] pixData,
  input logic              lineStart,
  input logic              frameStart,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic [1:0]        outChan
);

  assert_valid_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(pixValid));

  assert_clamp_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outData <= $past(pixData)));

  assert_quiet_after_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lineStart) || $past(frameStart)) |-> !outValid);

  assert_chan_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(outValid)) |->
      ((outChan[0] != $past(outChan[0])) && (outChan[1] == $past(outChan[1]))));

endmodule

bind bayer_clamp_demux bayer_clamp_demux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .pixData(pixData),
  .lineStart(lineStart), .frameStart(frameStart), .outValid(outValid),
  .outData(outData), .outChan(outChan)
);

// File: tb/test_bayer_clamp_demux.sv
`timescale 1ns/1ps
module test_bayer_clamp_demux;

  localparam int DW = 12;
  localparam int DUM = 2, LOB = 1, EFF = 5, TOB = 4;
  localparam int LOBL = 2, EFFL = 3, TOBL = 1;
  localparam int COLS = DUM + LOB + EFF + TOB;
  localparam int LINES = LOBL + EFFL + TOBL;
  localparam int MAXV = (1 << DW) - 1;

  // firstRed, firstGreen, obLevel, effBase, effStep, gap, lineStart-with-sample
  localparam int SCN [0:4][0:6] = '{
    '{1, 1,  64, 100, 37, 0, 0},
    '{0, 1, 200,  50, 91, 1, 0},
    '{1, 0,  10,   0,  3, 0, 1},
    '{0, 0, 300, 250, 13, 1, 1},
    '{1, 1, 900, 880,  5, 0, 0}
  };

  logic clk = 0, rst_n = 0;
  logic pixValid = 0, lineStart = 0, frameStart = 0;
  logic cfgFirstRed = 0, cfgFirstGreen = 0;
  logic [DW-1:0] pixData = '0;
  logic outValid;
  logic [DW-1:0] outData;
  logic [1:0] outChan;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // requirement-level model state
  int col = 1000, line = 1000, acc = 0, blk = 0;
  bit expV = 0;
  int expD = 0, expC = 0;
  string tagV = "R1";

  always #2 clk = ~clk;

  bayer_clamp_demux #(
    .DATA_W(DW), .DUMMY_COLS(DUM), .LEAD_OB_COLS(LOB), .EFF_COLS(EFF),
    .TRAIL_OB_COLS(TOB), .LEAD_OB_LINES(LOBL), .EFF_LINES(EFFL),
    .TRAIL_OB_LINES(TOBL)
  ) i_bayer_clamp_demux (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .pixData(pixData),
    .lineStart(lineStart), .frameStart(frameStart), .cfgFirstRed(cfgFirstRed),
    .cfgFirstGreen(cfgFirstGreen), .outValid(outValid), .outData(outData),
    .outChan(outChan)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(outValid == expV, tagV, int'(outValid), int'(expV));
    if (expV) begin
      check(int'(outData) == expD, "R7/R8 corrected data", int'(outData), expD);
      check(int'(outChan) == expC, "R5/R6 channel tag", int'(outChan), expC);
    end
  endtask

  task automatic step(input bit v, input int d, input bit ls, input bit fs);
    int recip, cIdx, rIdx;
    bit redL, grn;
    @(negedge clk);
    compare();
    pixValid = v; pixData = DW'(d); lineStart = ls; frameStart = fs;
    expV = 0;
    if (fs) begin
      col = COLS; line = -1; tagV = "R9 frame marker";
    end else if (ls) begin
      col = 0; line++; tagV = "R9 line marker";
      recip = (65536 + TOB / 2) / TOB;
      blk = (acc * recip) >>> 16;  // R7
      if (blk > MAXV) blk = MAXV;
      acc = 0;
    end else if (!v) begin
      tagV = "R10 idle cycle";
    end else begin
      if (col >= COLS - TOB && col < COLS) acc += d;
      cIdx = col - (DUM + LOB);
      rIdx = line - LOBL;
      if (cIdx < 0 || cIdx >= EFF || col >= COLS) tagV = "R2 column window";
      else if (rIdx < 0 || rIdx >= EFFL) tagV = "R3 line window";
      else begin
        tagV = "R4 output strobe";
        expV = 1;
        expD = (d > blk) ? d - blk : 0;
        redL = cfgFirstRed ^ rIdx[0];
        grn  = cfgFirstGreen ^ cIdx[0];
        expC = {~redL, ~grn};
      end
      if (col < COLS) col++;
    end
  endtask

  task automatic run_frame(input int fr, input int fg, input int ob, input int base,
                           input int stp, input int gap, input int lsPix);
    int d;
    cfgFirstRed = fr[0]; cfgFirstGreen = fg[0];
    step(0, 0, 0, 1);
    step(1, 4095, 0, 0);  // before first line: ignored (R2)
    for (int l = 0; l < LINES; l++) begin
      step(lsPix[0], 4095, 1, 0);
      for (int c = 0; c < COLS; c++) begin
        if (c < DUM + LOB) d = 3000 + c;
        else if (c < DUM + LOB + EFF) d = (base + stp * (l * 7 + c)) % 4096;
        else d = ob + ((l + c) % 3) * (1 + l);
        step(1, d, 0, 0);
        if (gap != 0) step(0, 0, 0, 0);
      end
      step(1, 4000, 0, 0);  // beyond last column (R2)
    end
    step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 0, "R1 reset valid", int'(outValid), 0);
    check(outData == 0, "R1 reset data", int'(outData), 0);
    check(outChan == 0, "R1 reset chan", int'(outChan), 0);
    rst_n = 1;
    // walk the scenario table
    for (int i = 0; i < 5; i++)
      run_frame(SCN[i][0], SCN[i][1], SCN[i][2], SCN[i][3], SCN[i][4], SCN[i][5], SCN[i][6]);
    // R1: mid-run reset clears the black reference
    @(negedge clk);
    compare();
    rst_n = 0; pixValid = 0; lineStart = 0; frameStart = 0;
    repeat (2) @(negedge clk);
    check(outValid == 0, "R1 reset valid mid-run", int'(outValid), 0);
    rst_n = 1;
    col = 1000; line = 1000; acc = 0; blk = 0; expV = 0; tagV = "R1 after reset";
    step(1, 77, 0, 0);  // no line yet: ignored
    run_frame(0, 1, 500, 400, 11, 0, 0);
    run_frame(1, 0, 20, 4090, 1, 1, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule